// File: doc/BRIEF.md
# PLL Divider/Multiplier Retune Sequencer

This block reprograms the two 3-bit control fields of a clock synthesiser, the reference divider (RFD) and the multiplication factor (MFD), so that the system clock never overshoots while the loop settles on a new multiplier. A host presents target values on `tgt_rfd_i` and `tgt_mfd_i` and pulses `start_i`. The sequencer then performs three register writes, each in its own clock cycle. First it writes a divider one step above the target. Next it writes the new multiplier. It then waits for the lock indication and writes the final divider, which brings the clock to the requested frequency.

The live field values appear on `rfd_o` and `mfd_o` and drive the synthesiser directly. The intended frequency relation is f_sys = f_ref × 2 × (MFD + 2) / 2^RFD, so the reset values RFD = 1 and MFD = 0 give twice the reference. After the multiplier write, the sequencer ignores `lock_i` for `SETTLE` wait cycles so that a lock level left over from the old setting is not taken as the new lock. If lock has not been accepted after `TIMEOUT` wait cycles, the sequence aborts and raises `err_o`.

Top module: `pll_retune_seq`

## Requirements
- R1: While `rst_n` is low and after it rises, `rfd_o` = 1, `mfd_o` = 0, and `busy_o`, `done_o` and `err_o` are 0.
- R2: A `start_i` sampled high at a clock edge while `busy_o` is low captures both targets. `busy_o` is high from the next cycle until the edge that ends the sequence.
- R3: At the first edge after the start edge, `rfd_o` becomes the target RFD plus one, and `mfd_o` is unchanged.
- R4: When the target RFD is 7, the value written by that first write is 7. It does not wrap to 0.
- R5: At the second edge after the start edge, `mfd_o` becomes the target MFD and `rfd_o` keeps its stepped value. The two fields are never written at the same edge.
- R6: The wait phase begins at the third edge after the start edge. At the wait edge with index c (starting from 0), lock is accepted only if `lock_i` is high and c ≥ `SETTLE`. Until lock is accepted or the sequence times out, both fields hold their values.
- R7: At the edge where lock is accepted, `rfd_o` becomes the target RFD, `done_o` is high for exactly one cycle, `err_o` stays 0, and `busy_o` falls.
- R8: A `start_i` pulse while `busy_o` is high is ignored. The running sequence finishes with the targets captured at its own start.
- R9: If lock has not been accepted by the wait edge with index c = `TIMEOUT`, that edge ends the sequence. `done_o` pulses, `err_o` goes high, `busy_o` falls, and the fields keep the stepped RFD and the target MFD. `err_o` stays high until the next accepted start clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request a retune (honoured only when idle) |
| tgt_rfd_i | input | 3 | Target reference divider field |
| tgt_mfd_i | input | 3 | Target multiplication factor field |
| lock_i | input | 1 | Lock indication from the lock detector |
| rfd_o | output | 3 | Live reference divider field |
| mfd_o | output | 3 | Live multiplication factor field |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse when a sequence ends |
| err_o | output | 1 | Last sequence timed out waiting for lock |

## Verification
Each result is due at a fixed edge counted from the start edge: the stepped divider after one edge, the multiplier after two, and wait index c falling on edge 3 + c. The end of the sequence therefore lands at edge 3 + max(`SETTLE`, first lock index), or at edge 3 + `TIMEOUT` if lock is never accepted. The bench drives inputs on the falling edge and samples after each rising edge. It computes from these formulas whether each edge is still busy, completes or aborts, and sweeps every one of the 64 target pairs along with several lock arrival indices.

// File: rtl/pll_retune_pkg.sv
// Package: shared field type, sequencer state and the saturating step.
// Assumes both control fields share one width.
package pll_retune_pkg;
    localparam int FIELD_W = 3;
    typedef logic [FIELD_W-1:0] field_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_STEP = 2'd1,
        ST_MULT = 2'd2,
        ST_WAIT = 2'd3
    } seq_state_t;

    // Divider one above v, held at the field maximum instead of wrapping.
    function automatic field_t step_up(input field_t v);
        return (v == '1) ? v : v + field_t'(1);
    endfunction
endpackage

// File: rtl/pll_lock_timer.sv
// Counts cycles spent waiting for lock. It reports when the settle window
// has passed and when the timeout has been reached. The count saturates.
// Assumes SETTLE <= TIMEOUT.
module pll_lock_timer #(
    parameter int SETTLE  = 2,
    parameter int TIMEOUT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic settled_o,
    output logic expired_o
);
    localparam int CNT_W = $clog2(TIMEOUT + 1);
    localparam logic [CNT_W-1:0] SETTLE_C  = CNT_W'(SETTLE);
    localparam logic [CNT_W-1:0] TIMEOUT_C = CNT_W'(TIMEOUT);

    logic [CNT_W-1:0] cnt_q;

    // Count wait cycles; clear whenever the sequencer is not waiting.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i)       cnt_q <= '0;
        else if (cnt_q != TIMEOUT_C) cnt_q <= cnt_q + CNT_W'(1);
    end

    assign settled_o = (cnt_q >= SETTLE_C);
    assign expired_o = (cnt_q >= TIMEOUT_C);

    // R9: the count never passes the timeout value.
    assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= TIMEOUT_C);
    // R6: the settle window always closes before the timeout does.
    assert_settle_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        expired_o |-> settled_o);
endmodule

// File: rtl/pll_field_regs.sv
// Holds the live divider and multiplier fields. Each field loads only on
// its own write strobe. Assumes the reset values give twice the reference.
module pll_field_regs
    import pll_retune_pkg::*;
#(
    parameter field_t RFD_RST = field_t'(1),
    parameter field_t MFD_RST = field_t'(0)
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   wr_rfd_i,
    input  field_t rfd_d_i,
    input  logic   wr_mfd_i,
    input  field_t mfd_d_i,
    output field_t rfd_o,
    output field_t mfd_o
);
    // Divider field register.
    always_ff @(posedge clk) begin
        if (!rst_n)        rfd_o <= RFD_RST;
        else if (wr_rfd_i) rfd_o <= rfd_d_i;
    end

    // Multiplier field register.
    always_ff @(posedge clk) begin
        if (!rst_n)        mfd_o <= MFD_RST;
        else if (wr_mfd_i) mfd_o <= mfd_d_i;
    end

    // R5: the two fields are never written at the same edge.
    assert_one_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_rfd_i && wr_mfd_i));
endmodule

// File: rtl/pll_retune_seq.sv
// Top: sequences a safe retune. It writes a stepped divider, then the
// multiplier, waits for an accepted lock and then writes the final divider.
// Assumes lock_i is synchronous to clk and SETTLE >= 1.
module pll_retune_seq
    import pll_retune_pkg::*;
#(
    parameter int SETTLE  = 2,
    parameter int TIMEOUT = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [2:0] tgt_rfd_i,
    input  logic [2:0] tgt_mfd_i,
    input  logic       lock_i,
    output logic [2:0] rfd_o,
    output logic [2:0] mfd_o,
    output logic       busy_o,
    output logic       done_o,
    output logic       err_o
);
    seq_state_t state_q;
    field_t     tgt_rfd_q, tgt_mfd_q;
    logic       settled, expired, accept, abort;
    logic       wr_rfd, wr_mfd;
    field_t     rfd_d;

    assign busy_o = (state_q != ST_IDLE);
    assign accept = (state_q == ST_WAIT) && settled && lock_i;
    assign abort  = (state_q == ST_WAIT) && !accept && expired;

    // Write strobes and divider data chosen by the current phase.
    always_comb begin
        wr_rfd = (state_q == ST_STEP) || accept;
        wr_mfd = (state_q == ST_MULT);
        rfd_d  = (state_q == ST_STEP) ? step_up(tgt_rfd_q) : tgt_rfd_q;
    end

    // Phase sequencing, target capture and end-of-sequence flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            tgt_rfd_q <= '0;
            tgt_mfd_q <= '0;
            done_o    <= 1'b0;
            err_o     <= 1'b0;
        end else begin
            done_o <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (start_i) begin
                    tgt_rfd_q <= tgt_rfd_i;
                    tgt_mfd_q <= tgt_mfd_i;
                    err_o     <= 1'b0;
                    state_q   <= ST_STEP;
                end
                ST_STEP: state_q <= ST_MULT;
                ST_MULT: state_q <= ST_WAIT;
                ST_WAIT: if (accept || abort) begin
                    done_o  <= 1'b1;
                    err_o   <= abort;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    pll_lock_timer #(.SETTLE(SETTLE), .TIMEOUT(TIMEOUT)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (state_q == ST_WAIT),
        .settled_o (settled),
        .expired_o (expired)
    );

    pll_field_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_rfd_i (wr_rfd),
        .rfd_d_i  (rfd_d),
        .wr_mfd_i (wr_mfd),
        .mfd_d_i  (tgt_mfd_q),
        .rfd_o    (rfd_o),
        .mfd_o    (mfd_o)
    );

    // R7: done is a single-cycle pulse.
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R2: no done while a sequence is still running.
    assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);
    // R7: a clean finish follows an observed lock.
    assert_final_after_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !err_o) |-> $past(lock_i));
    // R6: both fields hold while waiting for lock.
    assert_hold_in_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && $past(state_q == ST_WAIT)) |-> ($stable(mfd_o) && $stable(rfd_o)));
    // R4: the stepped divider never wraps to zero.
    assert_no_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MULT) |-> (rfd_o != '0));
endmodule

// File: tb/pll_retune_seq_tb.sv
module pll_retune_seq_tb;
    localparam int SETTLE  = 2;
    localparam int TIMEOUT = 8;
    localparam int NEVER   = 1000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [2:0] tgt_rfd_i = '0, tgt_mfd_i = '0;
    logic       lock_i = 1'b0;
    logic [2:0] rfd_o, mfd_o;
    logic       busy_o, done_o, err_o;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;  // 125 MHz

    pll_retune_seq #(.SETTLE(SETTLE), .TIMEOUT(TIMEOUT)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .tgt_rfd_i(tgt_rfd_i), .tgt_mfd_i(tgt_mfd_i), .lock_i(lock_i),
        .rfd_o(rfd_o), .mfd_o(mfd_o), .busy_o(busy_o),
        .done_o(done_o), .err_o(err_o)
    );

    task automatic chk(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // Advance one rising edge; return at the following falling edge.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // One full sequence. Lock rises at wait index lock_at. If poke is set,
    // a start with other targets arrives mid-sequence.
    task automatic run(input int tr, input int tm, input int lock_at, input bit poke);
        int  sr, pr, pm;
        bit  fin;
        sr = (tr == 7) ? 7 : tr + 1;
        pr = int'(rfd_o);
        pm = int'(mfd_o);
        start_i = 1'b1; tgt_rfd_i = 3'(tr); tgt_mfd_i = 3'(tm);
        lock_i = 1'b1;  // stale lock from the old setting
        tick();         // start edge
        start_i = 1'b0;
        chk("R2 busy after start", int'(busy_o), 1);
        chk("R9 err cleared by start", int'(err_o), 0);
        chk("R2 rfd unchanged at start", int'(rfd_o), pr);
        tgt_rfd_i = 3'(tr ^ 5); tgt_mfd_i = 3'(tm ^ 3);
        tick();         // step edge
        chk("R3/R4 stepped rfd", int'(rfd_o), sr);
        chk("R3 mfd unchanged", int'(mfd_o), pm);
        tick();         // multiplier edge
        chk("R5 mfd target", int'(mfd_o), tm);
        chk("R5 rfd still stepped", int'(rfd_o), sr);
        fin = 1'b0;
        for (int c = 0; !fin; c++) begin
            lock_i = (c >= lock_at);
            if (poke && c == 0) start_i = 1'b1;
            tick();
            start_i = 1'b0;
            if (c >= SETTLE && c >= lock_at) begin
                fin = 1'b1;
                chk("R7 final rfd", int'(rfd_o), tr);
                chk("R7 done", int'(done_o), 1);
                chk("R7 no err", int'(err_o), 0);
                chk("R7 busy low", int'(busy_o), 0);
            end else if (c >= TIMEOUT) begin
                fin = 1'b1;
                chk("R9 err", int'(err_o), 1);
                chk("R9 done", int'(done_o), 1);
                chk("R9 rfd stays stepped", int'(rfd_o), sr);
                chk("R9 busy low", int'(busy_o), 0);
            end else begin
                chk("R6 still busy", int'(busy_o), 1);
                chk("R6 rfd held", int'(rfd_o), sr);
                chk("R6 mfd held", int'(mfd_o), tm);
            end
        end
        lock_i = 1'b0;
        tick();
        chk("R7 done single pulse", int'(done_o), 0);
        chk("R8 mfd from own start", int'(mfd_o), tm);
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: got 0 expected 1 (run ended)");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        bit e;
        @(negedge clk);
        tick();
        chk("R1 rfd reset", int'(rfd_o), 1);
        chk("R1 mfd reset", int'(mfd_o), 0);
        chk("R1 busy reset", int'(busy_o), 0);
        chk("R1 done reset", int'(done_o), 0);
        chk("R1 err reset", int'(err_o), 0);
        rst_n = 1'b1;
        tick();
        chk("R1 idle after reset", int'(busy_o), 0);
        chk("R1 rfd after reset", int'(rfd_o), 1);
        // Exhaustive target sweep, lock stale-high (settle window applies).
        for (int r = 0; r < 8; r++)
            for (int m = 0; m < 8; m++)
                run(r, m, 0, (r + m) % 3 == 0);
        // Lock arrival indices, including right at and past the timeout.
        for (int la = 1; la <= TIMEOUT + 1; la++)
            run(la % 8, (la * 3) % 8, la, 1'b0);
        run(7, 2, NEVER, 1'b1);
        e = err_o;
        chk("R9 err held while idle", int'(e), 1);
        tick();
        chk("R9 err held", int'(err_o), 1);
        run(0, 7, 3, 1'b0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule